// File: doc/BRIEF.md
# Fixed-Priority Pipelined Bus Arbiter with Split Masking and Lock Parking

This block decides which of four masters owns a pipelined shared bus. Each cycle it takes the request vector, removes the masters that are waiting on a split transaction, and picks a winner by fixed priority. The winner's grant line is raised, and the grant then moves into the address phase and the data phase as the bus advances. The address-phase owner is driven on `hmaster_o`. Master 0 is a dummy that never makes real transfers. Its request line is used only as a pause input. Master 1 is the default owner when nobody requests.

A master that raises its lock line while it holds the grant keeps the grant until it drops the lock. A master that gets a split response is masked out of arbitration until the slave releases it. If the split master held a lock, the controller leaves state `ST_ARB` and enters state `ST_PARK`. In `ST_PARK` the bus is parked on the dummy master. The transition `ST_ARB -> ST_PARK` is taken on a split response to a locked data-phase master. The transition `ST_PARK -> ST_ARB` is taken on a ready cycle once that master's split bit has cleared. On that same edge the grant returns to the released master, so it can finish its locked sequence.

Top module: `shared_bus_arbiter`

## Requirements
- R1: Among unmasked requests the winner is chosen in the order master 3, then 0, then 2, then 1 (highest first). `hgrant_o[i]` is the grant bit of master i.
- R2: When no unmasked request is present and no lock or park applies, master 1 is granted (`hgrant_o` = 4'b0010).
- R3: The granted master changes only on a clock edge where `hready_i` is high. `hgrant_o` always has exactly one bit set.
- R4: On each ready edge outside `ST_PARK`, `hmaster_o` takes the binary number of the master that was granted before that edge. The data-phase owner takes the previous `hmaster_o` value on the same edge.
- R5: `hmastlock_o` equals the lock input of the currently granted master (and is 0 in `ST_PARK`). While it is high, the grant does not change, whatever the requests are.
- R6: A split response is `hresp_i` = 2'b11 while `hready_i` is low. It sets the split bit of the current data-phase owner. A master whose split bit is set cannot win arbitration.
- R7: A high bit in `hsplit_i` clears that master's split bit on the next edge. If a set and a clear hit the same bit in one cycle, the bit ends up set.
- R8: A split response to a data-phase owner that held the lock moves the controller to `ST_PARK`. On ready edges in that state, grant and `hmaster_o` are forced to master 0 and `hmastlock_o` is low. The first ready edge after that master's split bit clears grants it again and returns the controller to `ST_ARB`.
- R9: During reset the grant, address and data owners are all master 1 (`hgrant_o` = 4'b0010, `hmaster_o` = 1). `hmastlock_o` is the lock input of master 1, the split mask is empty and the state is `ST_ARB`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 4 | Bus request per master; bit 0 is the pause input |
| lock_i | input | 4 | Lock request per master |
| hready_i | input | 1 | Bus advance strobe |
| hresp_i | input | 2 | Slave response code; 2'b11 is split |
| hsplit_i | input | 4 | Per-master split release from slaves |
| hgrant_o | output | 4 | One-hot grant |
| hmaster_o | output | 4 | Address-phase master number |
| hmastlock_o | output | 1 | Locked access in progress |

## Verification
The assertions assume four things about the inputs. A split response appears only in the low-ready first cycle of a two-cycle response. The dummy master is never split. Request 0 is used only as a pause. The lock of a parked master is never relied on while it is masked. The stimulus is a directed sequence that obeys all four rules. Every split is followed by a ready cycle that still carries the split code, and a split is only issued once the intended master has reached the data phase. Releases are sent either alone or together with a set on the same bit.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int NUM_M = 4;
    localparam int IDX_W = $clog2(NUM_M);
    localparam int MID_W = 4;
    localparam int RESP_W = 2;

    typedef logic [IDX_W-1:0] mid_t;

    localparam mid_t DEFAULT_M = 2'd1;
    localparam mid_t DUMMY_M   = 2'd0;
    localparam logic [RESP_W-1:0] RESP_SPLIT = 2'b11;

    // winners from highest to lowest priority
    localparam mid_t PRIO_ORDER [NUM_M] = '{2'd3, 2'd0, 2'd2, 2'd1};

    typedef enum logic [0:0] {
        ST_ARB  = 1'b0,
        ST_PARK = 1'b1
    } arb_state_e;
endpackage

// File: rtl/arb_prio_enc.sv
module arb_prio_enc
    import arb_pkg::*;
(
    input  logic [NUM_M-1:0] req_i,
    output mid_t             win_o
);
    always_comb begin
        win_o = DEFAULT_M;
        // walk from lowest to highest priority, later hits overwrite
        for (int k = NUM_M - 1; k >= 0; k--) begin
            if (req_i[PRIO_ORDER[k]]) begin
                win_o = PRIO_ORDER[k];
            end
        end
    end
endmodule

// File: rtl/arb_split_mask.sv
module arb_split_mask
    import arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en_i,
    input  mid_t             set_id_i,
    input  logic [NUM_M-1:0] clr_i,
    output logic [NUM_M-1:0] mask_o
);
    logic [NUM_M-1:0] set_vec;

    for (genvar g = 0; g < NUM_M; g++) begin : g_set
        assign set_vec[g] = set_en_i && (set_id_i == mid_t'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_o <= '0;
        end else begin
            // set is applied after clear so it wins on a collision
            mask_o <= (mask_o & ~clr_i) | set_vec;
        end
    end
endmodule

// File: rtl/arb_master_pipe.sv
module arb_master_pipe
    import arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic advance_i,
    input  mid_t grant_d_i,
    input  logic force_dummy_i,
    input  logic lock_now_i,
    output mid_t grant_o,
    output mid_t addr_o,
    output mid_t data_o,
    output logic data_lock_o
);
    logic addr_lock_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_o     <= DEFAULT_M;
            addr_o      <= DEFAULT_M;
            data_o      <= DEFAULT_M;
            addr_lock_q <= 1'b0;
            data_lock_o <= 1'b0;
        end else if (advance_i) begin
            grant_o     <= grant_d_i;
            addr_o      <= force_dummy_i ? DUMMY_M : grant_o;
            data_o      <= addr_o;
            addr_lock_q <= lock_now_i;
            data_lock_o <= addr_lock_q;
        end
    end
endmodule

// File: rtl/shared_bus_arbiter.sv
module shared_bus_arbiter
    import arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_M-1:0]  req_i,
    input  logic [NUM_M-1:0]  lock_i,
    input  logic              hready_i,
    input  logic [RESP_W-1:0] hresp_i,
    input  logic [NUM_M-1:0]  hsplit_i,
    output logic [NUM_M-1:0]  hgrant_o,
    output logic [MID_W-1:0]  hmaster_o,
    output logic              hmastlock_o
);
    arb_state_e       st_q, st_d;
    mid_t             park_q;
    mid_t             winner, grant_d;
    mid_t             grant_q, addr_q, data_q;
    logic             data_lock_q;
    logic [NUM_M-1:0] mask_q;
    logic [NUM_M-1:0] req_open;
    logic             split_ev, split_locked, park_free, parked;

    assign split_ev     = !hready_i && (hresp_i == RESP_SPLIT);
    assign split_locked = split_ev && data_lock_q;
    assign req_open     = req_i & ~mask_q;
    assign park_free    = !mask_q[park_q];
    assign parked       = (st_q == ST_PARK);

    arb_prio_enc u_enc (
        .req_i (req_open),
        .win_o (winner)
    );

    arb_split_mask u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en_i (split_ev),
        .set_id_i (data_q),
        .clr_i    (hsplit_i),
        .mask_o   (mask_q)
    );

    arb_master_pipe u_pipe (
        .clk           (clk),
        .rst_n         (rst_n),
        .advance_i     (hready_i),
        .grant_d_i     (grant_d),
        .force_dummy_i (parked),
        .lock_now_i    (hmastlock_o),
        .grant_o       (grant_q),
        .addr_o        (addr_q),
        .data_o        (data_q),
        .data_lock_o   (data_lock_q)
    );

    // next-state and next-grant decision
    always_comb begin
        st_d    = st_q;
        grant_d = grant_q;
        unique case (st_q)
            ST_ARB: begin
                grant_d = hmastlock_o ? grant_q : winner;
                if (split_locked) begin
                    st_d = ST_PARK;
                end
            end
            ST_PARK: begin
                grant_d = park_free ? park_q : DUMMY_M;
                if (hready_i && park_free) begin
                    st_d = ST_ARB;
                end
            end
            default: begin
                st_d = ST_ARB;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_ARB;
            park_q <= DEFAULT_M;
        end else begin
            st_q <= st_d;
            if (split_locked) begin
                park_q <= data_q;
            end
        end
    end

    // outputs
    always_comb begin
        hgrant_o          = '0;
        hgrant_o[grant_q] = 1'b1;
        hmaster_o         = {{(MID_W-IDX_W){1'b0}}, addr_q};
        hmastlock_o       = !parked && lock_i[grant_q];
    end
endmodule

// File: rtl/arb_checker.sv
module arb_checker
    import arb_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [NUM_M-1:0] req_i,
    input logic             hready_i,
    input logic [NUM_M-1:0] hgrant_o,
    input logic [MID_W-1:0] hmaster_o,
    input logic             hmastlock_o,
    input logic [NUM_M-1:0] mask_q,
    input logic             parked
);
    function automatic logic [MID_W-1:0] gidx(input logic [NUM_M-1:0] g);
        logic [MID_W-1:0] r;
        r = '0;
        for (int i = 0; i < NUM_M; i++) begin
            if (g[i]) r = MID_W'(i);
        end
        return r;
    endfunction

    assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hgrant_o) == 1);

    assert_grant_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !hready_i |=> $stable(hgrant_o));

    assert_master_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hready_i && !parked) |=> (hmaster_o == $past(gidx(hgrant_o))));

    assert_lock_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hmastlock_o && hready_i) |=> $stable(hgrant_o));

    assert_default_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hready_i && !parked && !hmastlock_o && ((req_i & ~mask_q) == '0))
        |=> (hgrant_o == 4'b0010));

    assert_park_unlocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        parked |-> !hmastlock_o);

    for (genvar g = 0; g < NUM_M; g++) begin : g_mask
        assert_masked_no_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (hready_i && !parked && !hmastlock_o && mask_q[g] && !hgrant_o[g]
             && ((req_i & ~mask_q) != '0)) |=> !hgrant_o[g]);
    end
endmodule

bind shared_bus_arbiter arb_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .hready_i    (hready_i),
    .hgrant_o    (hgrant_o),
    .hmaster_o   (hmaster_o),
    .hmastlock_o (hmastlock_o),
    .mask_q      (mask_q),
    .parked      (parked)
);

// File: tb/tb_shared_bus_arbiter.sv
module tb_shared_bus_arbiter;
    localparam int CLK_P = 10;

    typedef struct {
        logic [3:0] gnt;
        logic [3:0] mst;
        logic       mlk;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req = '0, lock = '0, hsplit = '0;
    logic       hready = 1'b1;
    logic [1:0] hresp = '0;
    logic [3:0] hgrant, hmaster;
    logic       hmastlock;

    int   checks = 0;
    int   errors = 0;
    exp_t sb_q[$];
    bit   done = 0;

    always #(CLK_P/2) clk = ~clk;

    shared_bus_arbiter dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .lock_i(lock),
        .hready_i(hready), .hresp_i(hresp), .hsplit_i(hsplit),
        .hgrant_o(hgrant), .hmaster_o(hmaster), .hmastlock_o(hmastlock)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver: apply one cycle of inputs and queue the result expected after the edge
    task automatic step(input logic [3:0] r, input logic [3:0] l, input logic rdy,
                        input logic [1:0] rsp, input logic [3:0] sp,
                        input int eg, input int em, input logic el, input string tag);
        exp_t it;
        @(negedge clk);
        req = r; lock = l; hready = rdy; hresp = rsp; hsplit = sp;
        it.gnt = 4'(1 << eg);
        it.mst = 4'(em);
        it.mlk = el;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // monitor: compare after each edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                check({it.tag, " hgrant"}, 32'(hgrant), 32'(it.gnt));
                check({it.tag, " hmaster"}, 32'(hmaster), 32'(it.mst));
                check({it.tag, " hmastlock"}, 32'(hmastlock), 32'(it.mlk));
            end
        end
    end

    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 reset hgrant", 32'(hgrant), 32'h2);
        check("R9 reset hmaster", 32'(hmaster), 32'h1);
        check("R9 reset hmastlock", 32'(hmastlock), 32'h0);
        rst_n = 1'b1;
        //    req      lock     rdy   resp   split   G  A  L
        step(4'b0000, 4'b0000, 1'b1, 2'b00, 4'b0000, 1, 1, 1'b0, "R2 idle default");
        step(4'b0110, 4'b0000, 1'b1, 2'b00, 4'b0000, 2, 1, 1'b0, "R1 2 over 1");
        step(4'b0110, 4'b0000, 1'b1, 2'b00, 4'b0000, 2, 2, 1'b0, "R4 hmaster follows");
        step(4'b1001, 4'b0000, 1'b1, 2'b00, 4'b0000, 3, 2, 1'b0, "R1 3 over 0");
        step(4'b0101, 4'b0000, 1'b1, 2'b00, 4'b0000, 0, 3, 1'b0, "R1 pause over 2");
        step(4'b0110, 4'b0000, 1'b0, 2'b00, 4'b0000, 0, 3, 1'b0, "R3 hold on wait");
        step(4'b0110, 4'b0000, 1'b1, 2'b00, 4'b0000, 2, 0, 1'b0, "R4 advance");
        step(4'b0000, 4'b0000, 1'b1, 2'b00, 4'b0000, 1, 2, 1'b0, "R2 back to default");
        step(4'b0100, 4'b0100, 1'b1, 2'b00, 4'b0000, 2, 1, 1'b1, "R5 lock shown");
        step(4'b1100, 4'b0100, 1'b1, 2'b00, 4'b0000, 2, 2, 1'b1, "R5 lock holds vs 3");
        step(4'b1100, 4'b0000, 1'b1, 2'b00, 4'b0000, 3, 2, 1'b0, "R5 lock release");
        step(4'b0000, 4'b0000, 1'b1, 2'b00, 4'b0000, 1, 3, 1'b0, "R2 idle");
        step(4'b0000, 4'b0000, 1'b1, 2'b00, 4'b0000, 1, 1, 1'b0, "R4 data owner 3");
        step(4'b1000, 4'b0000, 1'b0, 2'b11, 4'b0000, 1, 1, 1'b0, "R6 split first cycle");
        step(4'b1000, 4'b0000, 1'b1, 2'b11, 4'b0000, 1, 1, 1'b0, "R6 split masks 3");
        step(4'b1010, 4'b0000, 1'b1, 2'b00, 4'b0000, 1, 1, 1'b0, "R6 still masked");
        step(4'b1000, 4'b0000, 1'b1, 2'b00, 4'b1000, 1, 1, 1'b0, "R7 release edge");
        step(4'b1000, 4'b0000, 1'b1, 2'b00, 4'b0000, 3, 1, 1'b0, "R7 released wins");
        step(4'b1000, 4'b0000, 1'b1, 2'b00, 4'b0000, 3, 3, 1'b0, "R4 fill pipe");
        step(4'b1000, 4'b0000, 1'b1, 2'b00, 4'b0000, 3, 3, 1'b0, "R4 data owner 3");
        step(4'b1000, 4'b0000, 1'b0, 2'b11, 4'b1000, 3, 3, 1'b0, "R7 set and clear");
        step(4'b1000, 4'b0000, 1'b1, 2'b11, 4'b0000, 1, 3, 1'b0, "R7 set wins");
        step(4'b0000, 4'b0000, 1'b1, 2'b00, 4'b1000, 1, 1, 1'b0, "R7 clear");
        step(4'b0000, 4'b0000, 1'b1, 2'b00, 4'b0000, 1, 1, 1'b0, "R2 idle");
        step(4'b0100, 4'b0100, 1'b1, 2'b00, 4'b0000, 2, 1, 1'b1, "R5 lock 2");
        step(4'b0100, 4'b0100, 1'b1, 2'b00, 4'b0000, 2, 2, 1'b1, "R5 lock 2 addr");
        step(4'b0100, 4'b0100, 1'b1, 2'b00, 4'b0000, 2, 2, 1'b1, "R5 lock 2 data");
        step(4'b0100, 4'b0100, 1'b0, 2'b11, 4'b0000, 2, 2, 1'b0, "R8 locked split");
        step(4'b0100, 4'b0100, 1'b1, 2'b11, 4'b0000, 0, 0, 1'b0, "R8 park dummy");
        step(4'b1100, 4'b0100, 1'b1, 2'b00, 4'b0000, 0, 0, 1'b0, "R8 park ignores 3");
        step(4'b1100, 4'b0100, 1'b1, 2'b00, 4'b0100, 0, 0, 1'b0, "R8 release edge");
        step(4'b1100, 4'b0100, 1'b1, 2'b00, 4'b0000, 2, 0, 1'b1, "R8 return to 2");
        step(4'b1100, 4'b0100, 1'b1, 2'b00, 4'b0000, 2, 2, 1'b1, "R5 relock holds");
        step(4'b0000, 4'b0000, 1'b1, 2'b00, 4'b0000, 1, 2, 1'b0, "R2 final idle");
        repeat (3) @(posedge clk);
        #(CLK_P/2);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule